// File: doc/BRIEF.md
# Multi-Output System Clock Router

This block produces three system clock enables (an auxiliary clock, a main clock and a sub-main clock) from a shared pool of six candidate sources. Five of the sources arrive as single-cycle enable pulses in the `clk` domain: a low-frequency crystal, a very-low-power internal oscillator, an internal reference, the digitally controlled oscillator (DCO) and a high-frequency crystal. The sixth source is a divided copy of the DCO that the block builds itself. Each output has its own 3-bit source select and its own 3-bit power-of-two divider. A second divider, stacked on the auxiliary clock, drives a pin-rate copy of it.

Gating follows power-mode rules. The sub-main clock has an off control. The main and auxiliary clocks stop when the power manager halts them. For each of the three clocks, an enabled peripheral request overrides the stop and keeps the clock running. There is no enable bit for the module oscillator. It runs exactly while its request path is enabled and some peripheral is asking for it.

A new select or divider code takes effect only at a divided-period boundary, so an output pulse is never shortened by reprogramming.

Top module: `sysclk_router`

## Requirements
- R1: A source select value maps as follows: 0 is the low-frequency crystal, 1 the very-low-power oscillator, 2 the internal reference, 3 the DCO, 4 the divided DCO and 5 the high-frequency crystal. Values 6 and 7 also pick the divided DCO.
- R2: A divider code k in the range 0..5 passes one output pulse per 2^k pulses of the selected source. Codes 6 and 7 divide by 32.
- R3: The divided-DCO source carries one pulse per 2^k DCO pulses, where k is `dco_div_code` under the same coding as R2.
- R4: `aux_pin_en` carries one pulse per 2^p pulses of `aux_clk_en`, where p is `aux_pin_div` under the coding of R2.
- R5: When `sub_off` is 1, `sub_clk_en` stays low unless `sub_req_en` and `sub_req` are both 1.
- R6: When `main_halt` (or `aux_halt`) is 1, `main_clk_en` (or `aux_clk_en`) stays low unless the matching request enable and request are both 1.
- R7: In the cycle after `mod_req_en` is 1 and any bit of `mod_req` is 1, `modosc_on` is 1. Otherwise it is 0.
- R8: A divider code that changes while a divided period is in progress is applied only after that period's output pulse.
- R9: A source select that changes while a divided period is in progress is applied only after that period's output pulse.
- R10: While `rst_n` is low and in the cycle after it is released, all outputs are 0.
- R11: With divider code 0 and a directly selected source, an output pulse follows its source pulse by exactly two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock in which all source pulses arrive |
| rst_n | input | 1 | Asynchronous active-low reset |
| xt1_tick | input | 1 | Low-frequency crystal pulse |
| vlo_tick | input | 1 | Very-low-power oscillator pulse |
| refo_tick | input | 1 | Internal reference pulse |
| dco_tick | input | 1 | DCO pulse |
| xt2_tick | input | 1 | High-frequency crystal pulse |
| dco_div_code | input | CODE_W | Divider code for the divided-DCO source |
| aux_sel | input | CODE_W | Auxiliary clock source select |
| aux_div | input | CODE_W | Auxiliary clock divider code |
| aux_pin_div | input | CODE_W | Extra divider code for the pin copy of the auxiliary clock |
| main_sel | input | CODE_W | Main clock source select |
| main_div | input | CODE_W | Main clock divider code |
| sub_sel | input | CODE_W | Sub-main clock source select |
| sub_div | input | CODE_W | Sub-main clock divider code |
| sub_off | input | 1 | Turns the sub-main clock off |
| aux_halt | input | 1 | Power-mode stop for the auxiliary clock |
| main_halt | input | 1 | Power-mode stop for the main clock |
| aux_req_en | input | 1 | Lets requests keep the auxiliary clock running |
| main_req_en | input | 1 | Lets requests keep the main clock running |
| sub_req_en | input | 1 | Lets requests keep the sub-main clock running |
| mod_req_en | input | 1 | Lets requests start the module oscillator |
| aux_req | input | 1 | Peripheral request for the auxiliary clock |
| main_req | input | 1 | Peripheral request for the main clock |
| sub_req | input | 1 | Peripheral request for the sub-main clock |
| mod_req | input | NUM_REQ | Peripheral requests for the module oscillator |
| aux_clk_en | output | 1 | Auxiliary clock enable pulse |
| main_clk_en | output | 1 | Main clock enable pulse |
| sub_clk_en | output | 1 | Sub-main clock enable pulse |
| aux_pin_en | output | 1 | Pin-rate auxiliary clock enable pulse |
| modosc_on | output | 1 | Module oscillator run request |

## Verification
A wrong internal state shows up as a wrong pulse count on the outputs. A corrupted period counter or a misdecoded code gives a count that differs from the source count shifted right by the code. The error shows within one divided period and stays there, so every configuration is checked by counting pulses over a fixed window and flushing before the comparison. A code or select that is applied too early is exposed by stopping a period partway, reprogramming, and counting how many source pulses the next output pulse needs. This is visible within one period. Gating and module-oscillator errors appear one or two edges after their controls change.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

   localparam int NUM_SRC = 6;

   typedef enum logic [2:0] {
      SRC_XT1    = 3'd0,
      SRC_VLO    = 3'd1,
      SRC_REFO   = 3'd2,
      SRC_DCO    = 3'd3,
      SRC_DCODIV = 3'd4,
      SRC_XT2    = 3'd5
   } src_e;

   // Unused select values fall back to the divided DCO.
   function automatic logic [2:0] map_sel(input logic [2:0] code);
      if (code > 3'd5) return 3'(SRC_DCODIV);
      return code;
   endfunction

endpackage

// File: rtl/sysclk_pow2_div.sv
module sysclk_pow2_div #(
   parameter int CODE_W   = 3,
   parameter int MAX_LOG2 = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              at_edge_o,
   output logic              tick_o
);
   localparam int CNT_W = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;

   if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code_w
      $error("sysclk_pow2_div: CODE_W out of range");
   end
   if (MAX_LOG2 < 0 || MAX_LOG2 > 16) begin : g_bad_log
      $error("sysclk_pow2_div: MAX_LOG2 out of range");
   end

   if (MAX_LOG2 == 0) begin : g_bypass
      // Divider disabled by parameter: every source pulse passes through.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_o <= 1'b0;
         else        tick_o <= tick_i;
      end
      assign at_edge_o = 1'b1;
   end else begin : g_count
      logic [CODE_W-1:0] act_q;
      logic [CODE_W-1:0] eff_code;
      logic [CNT_W-1:0]  cnt_q;
      logic [CNT_W-1:0]  lim;

      // The counter at zero means no period is in progress.
      assign at_edge_o = (cnt_q == '0);
      assign eff_code  = at_edge_o ? code_i : act_q;

      always_comb begin
         int unsigned sh;
         sh  = (int'(eff_code) > MAX_LOG2) ? MAX_LOG2 : int'(eff_code);
         lim = CNT_W'((32'd1 << sh) - 32'd1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q  <= '0;
            cnt_q  <= '0;
            tick_o <= 1'b0;
         end else begin
            act_q  <= eff_code;
            tick_o <= 1'b0;
            if (tick_i) begin
               if (cnt_q == lim) begin
                  cnt_q  <= '0;
                  tick_o <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end

      // R8: a code cannot move while a period stays open
      a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q != '0 && $past(cnt_q != '0)) |-> $stable(act_q));
   end

   // R2: every divided pulse is caused by a source pulse one edge earlier
   a_r2_pulse_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(tick_i));

endmodule

// File: rtl/sysclk_branch.sv
module sysclk_branch
   import sysclk_pkg::*;
#(
   parameter int CODE_W   = 3,
   parameter int MAX_LOG2 = 5,
   parameter int SRC_N    = NUM_SRC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_N-1:0]  src_i,
   input  logic [CODE_W-1:0] sel_i,
   input  logic [CODE_W-1:0] div_i,
   input  logic              run_i,
   output logic              clk_en_o
);
   if (SRC_N != NUM_SRC) begin : g_bad_src
      $error("sysclk_branch: source count must match the select coding");
   end
   if (CODE_W < 3) begin : g_bad_sel_w
      $error("sysclk_branch: select needs at least 3 bits");
   end

   logic [2:0] act_sel_q;
   logic [2:0] eff_sel;
   logic       picked;
   logic       at_edge;
   logic       div_tick;

   assign eff_sel = at_edge ? map_sel(sel_i[2:0]) : act_sel_q;
   assign picked  = src_i[eff_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_sel_q <= 3'(SRC_XT1);
      else        act_sel_q <= eff_sel;
   end

   sysclk_pow2_div #(.CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (picked),
      .code_i   (div_i),
      .at_edge_o(at_edge),
      .tick_o   (div_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_en_o <= 1'b0;
      else        clk_en_o <= div_tick & run_i;
   end

   // R9: the chosen source holds while a divided period is open
   a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!at_edge && $past(!at_edge)) |-> $stable(act_sel_q));

   // R1: the active selection always names one of the six sources
   a_r1_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
      act_sel_q <= 3'd5);

endmodule

// File: rtl/sysclk_router.sv
module sysclk_router
   import sysclk_pkg::*;
#(
   parameter int CODE_W   = 3,
   parameter int MAX_LOG2 = 5,
   parameter int NUM_REQ  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xt1_tick,
   input  logic               vlo_tick,
   input  logic               refo_tick,
   input  logic               dco_tick,
   input  logic               xt2_tick,
   input  logic [CODE_W-1:0]  dco_div_code,
   input  logic [CODE_W-1:0]  aux_sel,
   input  logic [CODE_W-1:0]  aux_div,
   input  logic [CODE_W-1:0]  aux_pin_div,
   input  logic [CODE_W-1:0]  main_sel,
   input  logic [CODE_W-1:0]  main_div,
   input  logic [CODE_W-1:0]  sub_sel,
   input  logic [CODE_W-1:0]  sub_div,
   input  logic               sub_off,
   input  logic               aux_halt,
   input  logic               main_halt,
   input  logic               aux_req_en,
   input  logic               main_req_en,
   input  logic               sub_req_en,
   input  logic               mod_req_en,
   input  logic               aux_req,
   input  logic               main_req,
   input  logic               sub_req,
   input  logic [NUM_REQ-1:0] mod_req,
   output logic               aux_clk_en,
   output logic               main_clk_en,
   output logic               sub_clk_en,
   output logic               aux_pin_en,
   output logic               modosc_on
);
   localparam int NUM_OUT = 3;
   localparam int IDX_AUX = 0;
   localparam int IDX_MAIN = 1;
   localparam int IDX_SUB = 2;

   if (NUM_REQ < 1) begin : g_bad_req
      $error("sysclk_router: NUM_REQ must be at least 1");
   end

   logic               dcodiv_tick;
   logic               dcodiv_edge;
   logic               pin_edge;
   logic [NUM_SRC-1:0] srcs;
   logic [CODE_W-1:0]  sel_a [NUM_OUT];
   logic [CODE_W-1:0]  div_a [NUM_OUT];
   logic [NUM_OUT-1:0] run_a;
   logic [NUM_OUT-1:0] out_a;

   // Divided-DCO source shared by all three branches.
   sysclk_pow2_div #(.CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2)) u_dco_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (dco_tick),
      .code_i   (dco_div_code),
      .at_edge_o(dcodiv_edge),
      .tick_o   (dcodiv_tick)
   );

   always_comb begin
      srcs                    = '0;
      srcs[int'(SRC_XT1)]    = xt1_tick;
      srcs[int'(SRC_VLO)]    = vlo_tick;
      srcs[int'(SRC_REFO)]   = refo_tick;
      srcs[int'(SRC_DCO)]    = dco_tick;
      srcs[int'(SRC_DCODIV)] = dcodiv_tick;
      srcs[int'(SRC_XT2)]    = xt2_tick;
   end

   assign sel_a[IDX_AUX]  = aux_sel;
   assign sel_a[IDX_MAIN] = main_sel;
   assign sel_a[IDX_SUB]  = sub_sel;
   assign div_a[IDX_AUX]  = aux_div;
   assign div_a[IDX_MAIN] = main_div;
   assign div_a[IDX_SUB]  = sub_div;

   assign run_a[IDX_AUX]  = !aux_halt  || (aux_req_en  && aux_req);
   assign run_a[IDX_MAIN] = !main_halt || (main_req_en && main_req);
   assign run_a[IDX_SUB]  = !sub_off   || (sub_req_en  && sub_req);

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_branch
      sysclk_branch #(.CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2), .SRC_N(NUM_SRC)) u_br (
         .clk     (clk),
         .rst_n   (rst_n),
         .src_i   (srcs),
         .sel_i   (sel_a[g]),
         .div_i   (div_a[g]),
         .run_i   (run_a[g]),
         .clk_en_o(out_a[g])
      );
   end

   assign aux_clk_en  = out_a[IDX_AUX];
   assign main_clk_en = out_a[IDX_MAIN];
   assign sub_clk_en  = out_a[IDX_SUB];

   // Pin copy of the auxiliary clock, divided once more.
   sysclk_pow2_div #(.CODE_W(CODE_W), .MAX_LOG2(MAX_LOG2)) u_pin_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (aux_clk_en),
      .code_i   (aux_pin_div),
      .at_edge_o(pin_edge),
      .tick_o   (aux_pin_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) modosc_on <= 1'b0;
      else        modosc_on <= mod_req_en && (|mod_req);
   end

   // R5: sub-main clock off without an enabled request
   a_r5_sub_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sub_off && !(sub_req_en && sub_req)) |-> !sub_clk_en);

   // R6: halted main and auxiliary clocks stay quiet
   a_r6_main_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $past(main_halt && !(main_req_en && main_req)) |-> !main_clk_en);
   a_r6_aux_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $past(aux_halt && !(aux_req_en && aux_req)) |-> !aux_clk_en);

   // R7: module oscillator follows its enabled requests
   a_r7_modosc_start: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_req_en && (|mod_req)) |=> modosc_on);
   a_r7_modosc_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !(mod_req_en && (|mod_req)) |=> !modosc_on);

   // R4: a pin pulse needs an auxiliary pulse one edge before
   a_r4_pin_from_aux: assert property (@(posedge clk) disable iff (!rst_n)
      aux_pin_en |-> $past(aux_clk_en));

   // R3: the divided DCO only pulses after a DCO pulse
   a_r3_dcodiv_source: assert property (@(posedge clk) disable iff (!rst_n)
      (dcodiv_tick && dcodiv_edge) |-> $past(dco_tick));

   // R10: no output activity during reset
   always_comb begin
      if (!rst_n) begin
         a_r10_reset_quiet: assert (!(aux_clk_en || main_clk_en || sub_clk_en ||
                                      aux_pin_en || modosc_on))
            else $error("R10 output active in reset");
      end
   end

   logic unused_edge;
   assign unused_edge = pin_edge;

endmodule

// File: tb/sysclk_router_tb_top.sv
module sysclk_router_tb_top;
   localparam int CW = 3;
   localparam int NR = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic xt1_tick = 0, vlo_tick = 0, refo_tick = 0, dco_tick = 0, xt2_tick = 0;
   logic [CW-1:0] dco_div_code = '0, aux_sel = '0, aux_div = '0, aux_pin_div = '0;
   logic [CW-1:0] main_sel = '0, main_div = '0, sub_sel = '0, sub_div = '0;
   logic sub_off = 0, aux_halt = 0, main_halt = 0;
   logic aux_req_en = 0, main_req_en = 0, sub_req_en = 0, mod_req_en = 0;
   logic aux_req = 0, main_req = 0, sub_req = 0;
   logic [NR-1:0] mod_req = '0;
   logic aux_clk_en, main_clk_en, sub_clk_en, aux_pin_en, modosc_on;

   int n_checks = 0;
   int n_fail = 0;
   int n_x1, n_v, n_r, n_d, n_x2;
   int c_aux, c_main, c_sub, c_pin;

   always #10 clk = ~clk;

   sysclk_router #(.CODE_W(CW), .MAX_LOG2(5), .NUM_REQ(NR)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .xt1_tick(xt1_tick), .vlo_tick(vlo_tick), .refo_tick(refo_tick),
      .dco_tick(dco_tick), .xt2_tick(xt2_tick),
      .dco_div_code(dco_div_code), .aux_sel(aux_sel), .aux_div(aux_div),
      .aux_pin_div(aux_pin_div), .main_sel(main_sel), .main_div(main_div),
      .sub_sel(sub_sel), .sub_div(sub_div), .sub_off(sub_off),
      .aux_halt(aux_halt), .main_halt(main_halt),
      .aux_req_en(aux_req_en), .main_req_en(main_req_en),
      .sub_req_en(sub_req_en), .mod_req_en(mod_req_en),
      .aux_req(aux_req), .main_req(main_req), .sub_req(sub_req),
      .mod_req(mod_req),
      .aux_clk_en(aux_clk_en), .main_clk_en(main_clk_en),
      .sub_clk_en(sub_clk_en), .aux_pin_en(aux_pin_en), .modosc_on(modosc_on)
   );

   task automatic check(input int got, input int exp, input string tag);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int shr(input int n, input int code);
      return n >> ((code > 5) ? 5 : code);
   endfunction

   function automatic int src_count(input int sel);
      case ((sel > 5) ? 4 : sel)
         0: return n_x1;
         1: return n_v;
         2: return n_r;
         3: return n_d;
         4: return shr(n_d, int'(dco_div_code));
         default: return n_x2;
      endcase
   endfunction

   // One cycle: wait for the falling edge and count outputs seen there.
   task automatic step();
      @(negedge clk);
      c_aux  += int'(aux_clk_en);
      c_main += int'(main_clk_en);
      c_sub  += int'(sub_clk_en);
      c_pin  += int'(aux_pin_en);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      xt1_tick = 0; vlo_tick = 0; refo_tick = 0; dco_tick = 0; xt2_tick = 0;
      @(negedge clk);
      check(int'(aux_clk_en) + int'(main_clk_en) + int'(sub_clk_en) +
            int'(aux_pin_en) + int'(modosc_on), 0, "R10 in reset");
      rst_n = 1'b1;
      n_x1 = 0; n_v = 0; n_r = 0; n_d = 0; n_x2 = 0;
      c_aux = 0; c_main = 0; c_sub = 0; c_pin = 0;
   endtask

   task automatic run(input int ncyc, input int px1, input int pv, input int pr,
                      input int pd, input int px2);
      for (int c = 0; c < ncyc; c++) begin
         xt1_tick  = (px1 != 0) && (c % px1 == 0);
         vlo_tick  = (pv  != 0) && (c % pv  == 0);
         refo_tick = (pr  != 0) && (c % pr  == 0);
         dco_tick  = (pd  != 0) && (c % pd  == 0);
         xt2_tick  = (px2 != 0) && (c % px2 == 0);
         n_x1 += int'(xt1_tick); n_v += int'(vlo_tick); n_r += int'(refo_tick);
         n_d  += int'(dco_tick); n_x2 += int'(xt2_tick);
         step();
      end
      xt1_tick = 0; vlo_tick = 0; refo_tick = 0; dco_tick = 0; xt2_tick = 0;
      for (int f = 0; f < 8; f++) step();
   endtask

   initial begin
      #(20 * 190000);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      // R10: outputs quiet right after release
      do_reset();
      step();
      check(int'(aux_clk_en) + int'(main_clk_en) + int'(sub_clk_en) +
            int'(aux_pin_en) + int'(modosc_on), 0, "R10 after release");

      // R1 and R2: every select and divider code on all three outputs
      dco_div_code = 3'd1;
      for (int s = 0; s < 8; s++) begin
         for (int d = 0; d < 8; d++) begin
            aux_sel = CW'(s); main_sel = CW'(s); sub_sel = CW'(s);
            aux_div = CW'(d); main_div = CW'(d); sub_div = CW'(d);
            aux_pin_div = '0;
            do_reset();
            run(256, 3, 7, 5, 1, 2);
            check(c_aux,  shr(src_count(s), d), $sformatf("R1/R2 aux sel%0d div%0d", s, d));
            check(c_main, shr(src_count(s), d), $sformatf("R1/R2 main sel%0d div%0d", s, d));
            check(c_sub,  shr(src_count(s), d), $sformatf("R1/R2 sub sel%0d div%0d", s, d));
            check(c_pin,  shr(src_count(s), d), $sformatf("R4 pin code0 sel%0d div%0d", s, d));
         end
      end

      // R3: divided-DCO coding
      for (int k = 0; k < 8; k++) begin
         dco_div_code = CW'(k);
         main_sel = 3'd4; main_div = 3'd0;
         do_reset();
         run(400, 0, 0, 0, 1, 0);
         check(c_main, shr(n_d, k), $sformatf("R3 dco div code %0d", k));
      end

      // R4: pin divider stacked on the auxiliary divider
      for (int a = 0; a < 3; a++) begin
         for (int p = 0; p < 8; p++) begin
            aux_sel = 3'd3; aux_div = CW'(a); aux_pin_div = CW'(p);
            do_reset();
            run(512, 0, 0, 0, 1, 0);
            check(c_pin, shr(shr(n_d, a), p), $sformatf("R4 aux div%0d pin%0d", a, p));
         end
      end

      // R11: two-edge latency on a direct source at divide-by-one
      aux_sel = 3'd0; aux_div = 3'd0; aux_pin_div = 3'd0;
      do_reset();
      xt1_tick = 1'b1; step(); xt1_tick = 1'b0;
      check(int'(aux_clk_en), 0, "R11 one edge after tick");
      step();
      check(int'(aux_clk_en), 1, "R11 two edges after tick");
      step();
      check(int'(aux_clk_en), 0, "R11 single pulse");

      // R5 and R6: gating
      aux_sel = 3'd3; main_sel = 3'd3; sub_sel = 3'd3;
      aux_div = 3'd0; main_div = 3'd0; sub_div = 3'd0;
      sub_off = 1; main_halt = 1; aux_halt = 1;
      do_reset();
      run(50, 0, 0, 0, 1, 0);
      check(c_sub, 0, "R5 sub off");
      check(c_main, 0, "R6 main halted");
      check(c_aux, 0, "R6 aux halted");
      check(c_pin, 0, "R6 pin follows halted aux");
      sub_req_en = 1; sub_req = 0; main_req_en = 0; main_req = 1;
      do_reset();
      run(50, 0, 0, 0, 1, 0);
      check(c_sub, 0, "R5 enable without request");
      check(c_main, 0, "R6 request without enable");
      sub_req = 1; main_req_en = 1; aux_req_en = 1; aux_req = 1;
      do_reset();
      run(50, 0, 0, 0, 1, 0);
      check(c_sub, 50, "R5 request keeps sub running");
      check(c_main, 50, "R6 request keeps main running");
      check(c_aux, 50, "R6 request keeps aux running");
      sub_off = 0; main_halt = 0; aux_halt = 0;
      sub_req_en = 0; main_req_en = 0; aux_req_en = 0;
      sub_req = 0; main_req = 0; aux_req = 0;

      // R7: module oscillator
      do_reset();
      mod_req_en = 1; mod_req = 4'b0100; step();
      check(int'(modosc_on), 1, "R7 start on request");
      mod_req = '0; step();
      check(int'(modosc_on), 0, "R7 stop without request");
      mod_req_en = 0; mod_req = 4'b0001; step();
      check(int'(modosc_on), 0, "R7 request path disabled");
      mod_req = '0;

      // R8: divider code change inside an open period
      main_sel = 3'd3; main_div = 3'd3;
      do_reset();
      run(3, 0, 0, 0, 1, 0);
      check(c_main, 0, "R8 partial period");
      main_div = 3'd0;
      run(5, 0, 0, 0, 1, 0);
      check(c_main, 1, "R8 old code finishes period");
      run(4, 0, 0, 0, 1, 0);
      check(c_main, 5, "R8 new code after boundary");

      // R9: select change inside an open period
      aux_sel = 3'd0; aux_div = 3'd2; aux_pin_div = 3'd0;
      do_reset();
      run(2, 1, 0, 0, 0, 0);
      aux_sel = 3'd1;
      run(2, 1, 0, 0, 0, 0);
      check(c_aux, 1, "R9 old source finishes period");
      run(4, 0, 1, 0, 0, 0);
      check(c_aux, 2, "R9 new source after boundary");
      run(4, 1, 0, 0, 0, 0);
      check(c_aux, 2, "R9 old source no longer counted");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule